// File: doc/BRIEF.md
# Dual-Bus FIR Multiply-Accumulate Engine

This block computes one output of a finite impulse response filter. Coefficients are held in a program-side memory and samples in a data-side memory. Each memory has its own address and read path, so one coefficient and one sample are fetched in the same cycle. A hardware multiplier forms one signed product per clock, and that product is added straight into a wide accumulator. As each sample is consumed, it is also copied one slot along the delay line. A pass therefore leaves the history shifted, ready for the next input sample to be written at slot 0.

Software, or a neighbouring controller, loads both memories through their write ports while the engine is idle. It then pulses `start` together with a tap count. The engine walks the taps from the oldest slot (index count-1) down to the newest (index 0) through a three-stage overlap: address issue, memory fetch, then multiply-accumulate. It finishes with a one-cycle `done` pulse. The accumulator is rounded and clamped to a 16-bit result, which stays on `result` until the next pass completes.

Top module: `fir_mac_engine`

## Requirements
- R1: While and after reset, `busy` and `done` are low and `result` is zero until the first pass completes.
- R2: A `start` pulse while idle with a tap count N in 1..DEPTH (16 by default) sets `busy` on the next cycle and clears the accumulator; a start with N = 0 or N > DEPTH is ignored, and `busy` stays low.
- R3: `done` is a single-cycle pulse that rises on the (N+3)-th rising edge counting the edge that accepted `start` as the first, which is three cycles after the last tap address is issued; `busy` falls on that same edge.
- R4: `result` equals the sum over k = 0..N-1 of coef[k] * sample[k] (16-bit two's complement operands, 40-bit accumulation), divided by 2^15 and rounded to nearest with halves rounded toward positive infinity.
- R5: A rounded value above 32767 gives 32767, and one below -32768 gives -32768.
- R6: A pass of N taps moves sample[k] into sample[k+1] for every k < N-1. Sample[0] and every slot at index N or above keep their contents, and the coefficients are never changed by a pass.
- R7: A `start` pulse while `busy` is high has no effect on the running pass: its latency and result are those of the accepted tap count.
- R8: Coefficient and sample writes presented while `busy` is high are ignored; writes while idle take effect for the next pass.
- R9: `result` changes only on the cycle where `done` is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe (idle only) |
| coef_waddr | input | 4 | Coefficient write index |
| coef_wdata | input | 16 | Coefficient value, signed Q15 |
| smp_we | input | 1 | Sample write strobe (idle only) |
| smp_waddr | input | 4 | Sample write index, 0 is newest |
| smp_wdata | input | 16 | Sample value, signed |
| start | input | 1 | Begin a pass |
| tap_count | input | 5 | Number of taps N for the pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 16 | Rounded and clamped filter output |

## Verification
The assertions assume that `start` and `tap_count` are sampled only on the edge that accepts them, and that the reset is held for at least one edge so that the pipeline valids start cleared. The bench applies every input on the falling edge and samples on the falling edge. It issues mid-pass starts and writes only to probe R7 and R8, and it keeps tap counts within 0..17 so that both the legal range and its two invalid neighbours are exercised. Each operand stays within 16-bit two's complement, so only the accumulated sum can reach the clamp limits that R5 targets.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 40;
  localparam int FRAC_W = 15;

  typedef logic signed [DATA_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/fir_sram.sv
module fir_sram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_tap_seq.sv
module fir_tap_seq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] tap_count,
  output logic          busy,
  output logic          clr_acc,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          mv_en,
  output logic [AW-1:0] mv_addr,
  output logic          exe_en,
  output logic          out_en
);
  logic          busy_q, iss_v_q, fet_v_q, fet_last_q, exe_last_q;
  logic [AW-1:0] iss_addr_q, fet_addr_q;
  logic [CW-1:0] ntaps_q, count_m1;
  logic          accept;

  assign accept   = start && !busy_q && (tap_count != '0) && (tap_count <= CW'(DEPTH));
  assign count_m1 = tap_count - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      iss_v_q    <= 1'b0;
      iss_addr_q <= '0;
      ntaps_q    <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      iss_v_q    <= 1'b1;
      iss_addr_q <= count_m1[AW-1:0];
      ntaps_q    <= tap_count;
    end else begin
      if (exe_last_q) busy_q <= 1'b0;
      if (iss_v_q) begin
        if (iss_addr_q == '0) iss_v_q <= 1'b0;
        else iss_addr_q <= iss_addr_q - AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fet_v_q    <= 1'b0;
      fet_last_q <= 1'b0;
      exe_last_q <= 1'b0;
      fet_addr_q <= '0;
    end else begin
      fet_v_q    <= iss_v_q;
      fet_last_q <= iss_v_q && (iss_addr_q == '0);
      exe_last_q <= fet_last_q;
      fet_addr_q <= iss_addr_q;
    end
  end

  assign busy    = busy_q;
  assign clr_acc = accept;
  assign rd_en   = iss_v_q;
  assign rd_addr = iss_addr_q;
  assign mv_en   = fet_v_q && ((CW'(fet_addr_q) + CW'(1)) < ntaps_q);
  assign mv_addr = fet_addr_q + AW'(1);
  assign exe_en  = fet_v_q;
  assign out_en  = exe_last_q;
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit
  import fir_mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_acc,
  input  logic  exe_en,
  input  logic  out_en,
  input  smp_t  coef,
  input  smp_t  smp,
  output acc_t  acc,
  output logic  done,
  output smp_t  result
);
  localparam int PW = 2 * DATA_W;
  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [ACC_W:0] SAT_LO = -SAT_HI - 1;
  localparam logic signed [ACC_W:0] HALF   = (ACC_W+1)'(64'sd1 <<< (FRAC_W-1));

  logic signed [PW-1:0]  prod;
  logic signed [ACC_W:0] rnd, shifted;
  acc_t acc_q;
  smp_t sat;

  assign prod    = coef * smp;
  assign rnd     = {acc_q[ACC_W-1], acc_q} + HALF;
  assign shifted = rnd >>> FRAC_W;

  always_comb begin
    if (shifted > SAT_HI)      sat = smp_t'(SAT_HI);
    else if (shifted < SAT_LO) sat = smp_t'(SAT_LO);
    else                       sat = smp_t'(shifted);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_acc) acc_q <= '0;
    else if (exe_en)    acc_q <= acc_q + ACC_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= out_en;
      if (out_en) result <= sat;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_mac_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coef_we,
  input  logic [AW-1:0]     coef_waddr,
  input  logic [DATA_W-1:0] coef_wdata,
  input  logic              smp_we,
  input  logic [AW-1:0]     smp_waddr,
  input  logic [DATA_W-1:0] smp_wdata,
  input  logic              start,
  input  logic [CW-1:0]     tap_count,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic          clr_acc, rd_en, mv_en, exe_en, out_en;
  logic [AW-1:0] rd_addr, mv_addr;
  logic          s_we;
  logic [AW-1:0] s_waddr;
  logic [DATA_W-1:0] s_wdata, coef_q, smp_q;
  acc_t          acc_w;
  smp_t          res_w;

  fir_tap_seq #(.DEPTH(DEPTH)) seq_i (
    .clk(clk), .rst(rst), .start(start), .tap_count(tap_count),
    .busy(busy), .clr_acc(clr_acc), .rd_en(rd_en), .rd_addr(rd_addr),
    .mv_en(mv_en), .mv_addr(mv_addr), .exe_en(exe_en), .out_en(out_en)
  );

  // Program-side memory: coefficients
  fir_sram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) pmem_i (
    .clk(clk), .we(coef_we && !busy), .waddr(coef_waddr), .wdata(coef_wdata),
    .re(rd_en), .raddr(rd_addr), .rdata(coef_q)
  );

  // Data-side memory: the delay line; its write port carries the move while busy
  always_comb begin
    if (busy) begin
      s_we    = mv_en;
      s_waddr = mv_addr;
      s_wdata = smp_q;
    end else begin
      s_we    = smp_we;
      s_waddr = smp_waddr;
      s_wdata = smp_wdata;
    end
  end

  fir_sram #(.WIDTH(DATA_W), .DEPTH(DEPTH)) dmem_i (
    .clk(clk), .we(s_we), .waddr(s_waddr), .wdata(s_wdata),
    .re(rd_en), .raddr(rd_addr), .rdata(smp_q)
  );

  fir_mac_unit mac_i (
    .clk(clk), .rst(rst), .clr_acc(clr_acc), .exe_en(exe_en), .out_en(out_en),
    .coef(smp_t'(coef_q)), .smp(smp_t'(smp_q)), .acc(acc_w),
    .done(done), .result(res_w)
  );

  assign result = res_w;
endmodule

// File: rtl/fir_mac_chk.sv
module fir_mac_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] tap_count,
  input logic          busy,
  input logic          done,
  input logic [15:0]   result,
  input logic          rd_en
);
  logic ok_cnt;
  assign ok_cnt = (tap_count != '0) && (tap_count <= CW'(DEPTH));

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && ok_cnt) |=> busy); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(start && ok_cnt)) |=> !busy); // R2
  AST_ISSUE_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R9
endmodule

bind fir_mac_engine fir_mac_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .tap_count(tap_count),
  .busy(busy), .done(done), .result(result), .rd_en(rd_en)
);

// File: tb/fir_mac_engine_tb_top.sv
`timescale 1ns/1ps
module fir_mac_engine_tb_top;
  localparam int DEPTH = 16;
  localparam int NV = 9;
  // columns: taps, coefficient fill, sample fill, expected result
  localparam int V_N   [NV] = '{1, 4, 16, 4, 2, 3, 1, 1, 2};
  localparam int V_C   [NV] = '{16384, 8192, 32767, 16384, 32767, 1, 16384, -16384, 16384};
  localparam int V_S   [NV] = '{1000, -2000, 100, 16384, -32768, 1, 1, 1, 1};
  localparam int V_EXP [NV] = '{500, -2000, 1600, 32767, -32768, 0, 1, 0, 1};

  logic clk = 0, rst = 1;
  logic coef_we = 0, smp_we = 0, start = 0;
  logic [3:0] coef_waddr = 0, smp_waddr = 0;
  logic [15:0] coef_wdata = 0, smp_wdata = 0;
  logic [4:0] tap_count = 0;
  logic busy, done;
  logic [15:0] result;

  int checks = 0, errors = 0, cyc = 0;
  int mc[DEPTH], ms[DEPTH];

  always #2 clk = ~clk;

  fir_mac_engine dut_i (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_waddr(coef_waddr),
    .coef_wdata(coef_wdata), .smp_we(smp_we), .smp_waddr(smp_waddr),
    .smp_wdata(smp_wdata), .start(start), .tap_count(tap_count),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr_coef(int a, int d);
    coef_we = 1; coef_waddr = 4'(a); coef_wdata = 16'(d);
    @(negedge clk); coef_we = 0;
    mc[a] = d;
  endtask

  task automatic wr_smp(int a, int d);
    smp_we = 1; smp_waddr = 4'(a); smp_wdata = 16'(d);
    @(negedge clk); smp_we = 0;
    ms[a] = d;
  endtask

  task automatic onehot(int p);
    for (int i = 0; i < DEPTH; i++) wr_coef(i, (i == p) ? 32767 : 0);
  endtask

  // expected from R4/R5/R6: oldest to newest, move k into k+1 for k < n-1
  function automatic int model_pass(int n);
    longint acc = 0, r;
    for (int k = n - 1; k >= 0; k--) begin
      acc += longint'(mc[k]) * longint'(ms[k]);
      if (k + 1 < n) ms[k+1] = ms[k];
    end
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // inj: 0 none, 1 second start mid-pass (R7), 2 writes mid-pass (R8)
  task automatic run_pass(int n, int inj, output int got);
    int exp, seen;
    exp = model_pass(n);
    seen = -1;
    start = 1; tap_count = 5'(n);
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
    for (int j = 0; j < n + 12; j++) begin
      if (done === 1'b1) begin seen = j; break; end
      if (j > 0) chk(busy === 1'b1, "R3 busy during pass", int'(busy), 1);
      if (inj == 1 && j == 1) begin start = 1; tap_count = 5'd1; end
      if (inj == 2 && j == 1) begin
        smp_we = 1; smp_waddr = 0; smp_wdata = 16'sd12345;
        coef_we = 1; coef_waddr = 0; coef_wdata = 16'sd5;
      end
      @(negedge clk);
      start = 0; smp_we = 0; coef_we = 0;
    end
    chk(seen == n + 2, (inj == 1) ? "R7 latency" : "R3 done latency", seen, n + 2);
    chk(busy === 1'b0, "R3 busy falls with done", int'(busy), 0);
    got = int'($signed(result));
    chk(got == exp, (inj == 1) ? "R7 result" : "R4 result", got, exp);
    @(negedge clk);
    chk(done === 1'b0, "R3 done single pulse", int'(done), 0);
  endtask

  initial begin
    int got, hold;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done === 1'b0, "R1 done in reset", int'(done), 0);
    chk(result === 16'd0, "R1 result in reset", int'(result), 0);
    rst = 0;
    @(negedge clk);
    chk(result === 16'd0 && busy === 1'b0, "R1 after reset", int'(result), 0);

    // R2: invalid tap counts are ignored
    for (int t = 0; t < 2; t++) begin
      start = 1; tap_count = (t == 0) ? 5'd0 : 5'd17;
      @(negedge clk); start = 0;
      chk(busy === 1'b0, "R2 bad count ignored", int'(busy), 0);
      repeat (4) @(negedge clk);
      chk(done === 1'b0, "R2 no done on bad count", int'(done), 0);
    end

    // vector table: constant fills, covering rounding and clamping (R4, R5)
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < DEPTH; i++) begin
        wr_coef(i, V_C[v]);
        wr_smp(i, V_S[v]);
      end
      run_pass(V_N[v], 0, got);
      chk(got == V_EXP[v], (v == 3 || v == 4) ? "R5 clamp vector" : "R4 table vector", got, V_EXP[v]);
    end

    // R6 delay-line move, observed through one-hot coefficient reads
    for (int i = 0; i < DEPTH; i++) wr_smp(i, (i + 1) * 100);
    onehot(4);
    run_pass(5, 0, got);
    chk(got == 500, "R6 pass reads oldest", got, 500);
    onehot(5);
    run_pass(6, 0, got);
    chk(got == 600, "R6 slot beyond N untouched", got, 600);
    onehot(2);
    run_pass(3, 0, got);
    chk(got == 100, "R6 shifted contents", got, 100);

    // R7: second start mid-pass
    for (int i = 0; i < DEPTH; i++) wr_smp(i, 50 * i - 300);
    onehot(3);
    run_pass(8, 1, got);

    // R8: writes mid-pass ignored, idle writes applied
    onehot(0);
    run_pass(4, 2, got);
    run_pass(1, 0, got);
    chk(got != 12345, "R8 busy write ignored", got, ms[0]);
    wr_smp(0, 777);
    run_pass(1, 0, got);
    chk(got == 777, "R8 idle write applied", got, 777);

    // R9: result holds while idle
    hold = int'($signed(result));
    repeat (6) @(negedge clk);
    chk(int'($signed(result)) == hold, "R9 result holds", int'($signed(result)), hold);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule